// File: doc/BRIEF.md
# Power-Up Identity and Power Configuration Loader

After reset this block settles the USB identity and power attributes of the device. In its first cycle it samples the idle levels of the two-wire clock and data lines and of a low-power status pin. If both bus lines are pulled high, it assumes a serial configuration memory may be attached. It then reads an eight-byte record from address 0 of that memory and keeps the record only if its last byte carries the expected signature.

When the record is absent or rejected, the block uses hardwired vendor and product IDs. It also builds the wake-up and power settings from the sampled levels of the two bus lines, which then act as pin straps. The results are registered and stay fixed until the next reset. A single-cycle done strobe marks the moment they become final. Descriptor serving and the USB logic that consumes these values sit elsewhere.

The bus master is open-drain: each line has a pull-low enable, and a released line is high only through its external pull-up. The serial clock runs at one quarter of a bit per `QTR_DIV` system clocks.

Top module: `cfg_loader`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `done_o` is 0, all configuration outputs are 0 and both pull-low enables are 0.
- R2: When both bus lines read high in the first cycle after reset, the block issues this sequence on the bus: START, device byte 0xA0, word address 0x00, repeated START, device byte 0xA1, eight read bytes (the first seven acknowledged, the last not acknowledged), STOP.
- R3: A record whose byte 7 equals 0x58 is valid. For a valid record, `vid_o` = {byte1, byte0}, `pid_o` = {byte3, byte2}, `attr_o` = byte4, `maxpwr_o` = byte5, and `rom_used_o` = 1.
- R4: For a valid record, `rwake_o` equals bit 5 of byte4 and `buspwr_o` equals the inverse of bit 6 of byte4.
- R5: When byte 7 differs from 0x58, every record byte is ignored. The outputs are `vid_o` = 0x04E2, `pid_o` = 0x1410, `maxpwr_o` = 0x32, `rom_used_o` = 0, and the strap-derived values of R7.
- R6: A missing acknowledge after the device address byte means no memory is present. The block then issues STOP and produces the same fallback outputs as R5.
- R7: On the fallback path, `rwake_o` = 1 exactly when the data strap read low and `buspwr_o` = 1 exactly when the clock strap read low. `attr_o` = 0x80, plus 0x40 when self-powered (`buspwr_o` = 0), plus 0x20 when `rwake_o` = 1.
- R8: If either strap reads low, no bus access is made: both pull-low enables stay 0 until the next reset, and the fallback outputs are used even when a valid memory is connected.
- R9: `susp_pol_o` equals the level of `lowpwr_i` sampled in the first cycle after reset.
- R10: `done_o` is high for exactly one cycle, in the same cycle that the outputs take their final values. The outputs then hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level of the two-wire clock line |
| sda_i | input | 1 | Level of the two-wire data line |
| lowpwr_i | input | 1 | Level of the low-power status pin at power-up |
| scl_oe_o | output | 1 | Pull clock line low when 1 |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| vid_o | output | 16 | Vendor ID |
| pid_o | output | 16 | Product ID |
| attr_o | output | 8 | Configuration attribute byte |
| maxpwr_o | output | 8 | Maximum power byte |
| rwake_o | output | 1 | Remote wake-up supported |
| buspwr_o | output | 1 | Device is bus-powered |
| susp_pol_o | output | 1 | Sampled polarity for the suspend indication |
| rom_used_o | output | 1 | Outputs came from a valid memory record |
| done_o | output | 1 | One-cycle strobe when configuration is final |

## Verification
The assertions assume that the strap and low-power levels are steady from reset release through the sampling cycle. They also assume the peripheral changes the data line only while the clock is low, apart from its start and stop conditions. The bench model of the memory watches the lines on the system clock and reacts only to clock falling edges, so it never drives data while the clock is high. Each scenario holds its pull levels constant for the whole run between resets. Cases cover a good record with two attribute patterns, a bad signature, an absent device, all four strap combinations, and a valid memory hidden behind a low strap.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    TW_START = 2'd0,
    TW_STOP  = 2'd1,
    TW_BYTE  = 2'd2
  } tw_op_e;

  localparam logic [7:0] DEV_WRITE = 8'hA0;
  localparam logic [7:0] DEV_READ  = 8'hA1;
  localparam logic [7:0] REC_SIG   = 8'h58;
  localparam int         REC_LEN   = 8;

  typedef struct packed {
    logic [15:0] vid;
    logic [15:0] pid;
    logic [7:0]  attr;
    logic [7:0]  maxpwr;
    logic        rwake;
    logic        buspwr;
    logic        rom_used;
  } cfg_t;

endpackage

// File: rtl/tw_engine.sv
module tw_engine
  import cfg_loader_pkg::*;
#(
  parameter int QTR_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  tw_op_e     op,
  input  logic       is_read,
  input  logic [7:0] wr_byte,
  input  logic       rd_nack,
  input  logic       sda_in,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       ack_ok,
  output logic       scl_low,
  output logic       sda_low
);

  localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;

  tw_op_e      op_q;
  logic [CW-1:0] cnt;
  logic [1:0]  phase;
  logic [3:0]  bitc;
  logic [8:0]  tx_sh;
  logic [8:0]  rx_sh;

  assign rx_byte = rx_sh[8:1];
  assign ack_ok  = ~rx_sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= TW_START;
      cnt     <= '0;
      phase   <= '0;
      bitc    <= '0;
      tx_sh   <= '1;
      rx_sh   <= '1;
      busy    <= 1'b0;
      done    <= 1'b0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy  <= 1'b1;
          op_q  <= op;
          cnt   <= '0;
          phase <= '0;
          bitc  <= '0;
          tx_sh <= is_read ? {8'hFF, rd_nack} : {wr_byte, 1'b1};
        end
      end else if (cnt != CW'(QTR_DIV - 1)) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt   <= '0;
        phase <= phase + 2'd1;
        unique case (op_q)
          TW_START: begin
            unique case (phase)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              default: begin
                scl_low <= 1'b1;
                busy    <= 1'b0;
                done    <= 1'b1;
              end
            endcase
          end
          TW_STOP: begin
            unique case (phase)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              default: begin
                busy <= 1'b0;
                done <= 1'b1;
              end
            endcase
          end
          default: begin
            unique case (phase)
              2'd0: sda_low <= ~tx_sh[8];
              2'd1: scl_low <= 1'b0;
              2'd2: rx_sh   <= {rx_sh[7:0], sda_in};
              default: begin
                scl_low <= 1'b1;
                tx_sh   <= {tx_sh[7:0], 1'b1};
                bitc    <= bitc + 4'd1;
                if (bitc == 4'd8) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                end
              end
            endcase
          end
        endcase
      end
    end
  end

  // R2
  cmd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy);

  // R2
  sda_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && op_q == TW_BYTE && !scl_low && $past(!scl_low)) |-> $stable(sda_low));

endmodule

// File: rtl/cfg_resolve.sv
module cfg_resolve
  import cfg_loader_pkg::*;
#(
  parameter logic [15:0] DEF_VID    = 16'h04E2,
  parameter logic [15:0] DEF_PID    = 16'h1410,
  parameter logic [7:0]  DEF_MAXPWR = 8'h32
) (
  input  logic       rom_ok,
  input  logic [7:0] b0,
  input  logic [7:0] b1,
  input  logic [7:0] b2,
  input  logic [7:0] b3,
  input  logic [7:0] b4,
  input  logic [7:0] b5,
  input  logic [7:0] sig,
  input  logic       sda_strap,
  input  logic       scl_strap,
  output cfg_t       cfg
);

  logic use_rom;
  logic def_wake;
  logic def_bus;

  assign use_rom  = rom_ok && (sig == REC_SIG);
  assign def_wake = ~sda_strap;
  assign def_bus  = ~scl_strap;

  always_comb begin
    if (use_rom) begin
      cfg.vid      = {b1, b0};
      cfg.pid      = {b3, b2};
      cfg.attr     = b4;
      cfg.maxpwr   = b5;
      cfg.rwake    = b4[5];
      cfg.buspwr   = ~b4[6];
      cfg.rom_used = 1'b1;
    end else begin
      cfg.vid      = DEF_VID;
      cfg.pid      = DEF_PID;
      cfg.attr     = {1'b1, ~def_bus, def_wake, 5'b0};
      cfg.maxpwr   = DEF_MAXPWR;
      cfg.rwake    = def_wake;
      cfg.buspwr   = def_bus;
      cfg.rom_used = 1'b0;
    end
  end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int          QTR_DIV    = 4,
  parameter logic [15:0] DEF_VID    = 16'h04E2,
  parameter logic [15:0] DEF_PID    = 16'h1410,
  parameter logic [7:0]  DEF_MAXPWR = 8'h32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        lowpwr_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  output logic [15:0] vid_o,
  output logic [15:0] pid_o,
  output logic [7:0]  attr_o,
  output logic [7:0]  maxpwr_o,
  output logic        rwake_o,
  output logic        buspwr_o,
  output logic        susp_pol_o,
  output logic        rom_used_o,
  output logic        done_o
);

  localparam logic [3:0] STEP_RD0  = 4'd5;
  localparam logic [3:0] STEP_RDN  = STEP_RD0 + 4'(REC_LEN - 1);
  localparam logic [3:0] STEP_STOP = STEP_RDN + 4'd1;

  typedef enum logic [2:0] {S_SAMPLE, S_ISSUE, S_WAIT, S_DECIDE, S_DONE} st_e;

  st_e        state_q;
  logic [3:0] step_q;
  logic       sda_s_q, scl_s_q, pol_q;
  logic       use_bus_q, nack_q;
  logic [7:0] rec_q [REC_LEN];

  tw_op_e     eng_op;
  logic       eng_go, eng_rd, eng_nack;
  logic [7:0] eng_wr;
  logic       eng_busy, eng_done, eng_ack;
  logic [7:0] eng_rx;
  logic       scl_low, sda_low;
  cfg_t       cfg_next;

  always_comb begin
    eng_go   = (state_q == S_ISSUE);
    eng_rd   = (step_q >= STEP_RD0) && (step_q <= STEP_RDN);
    eng_nack = (step_q == STEP_RDN);
    if (step_q == 4'd0 || step_q == 4'd3)  eng_op = TW_START;
    else if (step_q == STEP_STOP)          eng_op = TW_STOP;
    else                                   eng_op = TW_BYTE;
    if (step_q == 4'd1)      eng_wr = DEV_WRITE;
    else if (step_q == 4'd4) eng_wr = DEV_READ;
    else                     eng_wr = 8'h00;
  end

  tw_engine #(.QTR_DIV(QTR_DIV)) u_eng (
    .clk(clk), .rst(rst), .go(eng_go), .op(eng_op), .is_read(eng_rd),
    .wr_byte(eng_wr), .rd_nack(eng_nack), .sda_in(sda_i),
    .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx), .ack_ok(eng_ack),
    .scl_low(scl_low), .sda_low(sda_low)
  );

  assign scl_oe_o = scl_low;
  assign sda_oe_o = sda_low;

  cfg_resolve #(.DEF_VID(DEF_VID), .DEF_PID(DEF_PID), .DEF_MAXPWR(DEF_MAXPWR)) u_res (
    .rom_ok(use_bus_q && !nack_q),
    .b0(rec_q[0]), .b1(rec_q[1]), .b2(rec_q[2]), .b3(rec_q[3]),
    .b4(rec_q[4]), .b5(rec_q[5]), .sig(rec_q[REC_LEN-1]),
    .sda_strap(sda_s_q), .scl_strap(scl_s_q), .cfg(cfg_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_SAMPLE;
      step_q    <= '0;
      sda_s_q   <= 1'b1;
      scl_s_q   <= 1'b1;
      pol_q     <= 1'b0;
      use_bus_q <= 1'b0;
      nack_q    <= 1'b0;
      for (int i = 0; i < REC_LEN; i++) rec_q[i] <= '0;
    end else begin
      unique case (state_q)
        S_SAMPLE: begin
          sda_s_q   <= sda_i;
          scl_s_q   <= scl_i;
          pol_q     <= lowpwr_i;
          use_bus_q <= sda_i & scl_i;
          state_q   <= (sda_i & scl_i) ? S_ISSUE : S_DECIDE;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (eng_done) begin
          if (step_q == STEP_STOP) begin
            state_q <= S_DECIDE;
          end else if ((step_q == 4'd1 || step_q == 4'd2 || step_q == 4'd4) && !eng_ack) begin
            nack_q  <= 1'b1;
            step_q  <= STEP_STOP;
            state_q <= S_ISSUE;
          end else begin
            if (eng_rd) rec_q[3'(step_q - STEP_RD0)] <= eng_rx;
            step_q  <= step_q + 4'd1;
            state_q <= S_ISSUE;
          end
        end
        S_DECIDE: state_q <= S_DONE;
        default:  state_q <= S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_o      <= '0;
      pid_o      <= '0;
      attr_o     <= '0;
      maxpwr_o   <= '0;
      rwake_o    <= 1'b0;
      buspwr_o   <= 1'b0;
      susp_pol_o <= 1'b0;
      rom_used_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= (state_q == S_DECIDE);
      if (state_q == S_DECIDE) begin
        vid_o      <= cfg_next.vid;
        pid_o      <= cfg_next.pid;
        attr_o     <= cfg_next.attr;
        maxpwr_o   <= cfg_next.maxpwr;
        rwake_o    <= cfg_next.rwake;
        buspwr_o   <= cfg_next.buspwr;
        susp_pol_o <= pol_q;
        rom_used_o <= cfg_next.rom_used;
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DONE) |=> $stable({vid_o, pid_o, attr_o, maxpwr_o, rwake_o,
                                      buspwr_o, susp_pol_o, rom_used_o}));

  // R8
  strap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !use_bus_q |-> (!scl_oe_o && !sda_oe_o));

  // R5
  default_id_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !rom_used_o) |-> (vid_o == DEF_VID && pid_o == DEF_PID && maxpwr_o == DEF_MAXPWR));

  // R4
  attr_power_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rwake_o == attr_o[5] && buspwr_o == !attr_o[6]));

endmodule

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic scl_pull = 1'b1, sda_pull = 1'b1, lowpwr = 1'b0, present = 1'b0;
  logic [7:0] mem [8];
  logic slv_low;
  logic scl_oe, sda_oe;
  logic [15:0] vid, pid;
  logic [7:0]  attr, maxpwr;
  logic rwake, buspwr, spol, romu, done;

  wire scl_line = scl_oe ? 1'b0 : scl_pull;
  wire sda_line = (sda_oe | slv_low) ? 1'b0 : sda_pull;

  cfg_loader u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line), .lowpwr_i(lowpwr),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .vid_o(vid), .pid_o(pid),
    .attr_o(attr), .maxpwr_o(maxpwr), .rwake_o(rwake), .buspwr_o(buspwr),
    .susp_pol_o(spol), .rom_used_o(romu), .done_o(done)
  );

  // memory model, sampled on the system clock
  logic ps, pd, go_tx, addr_ph, acked;
  int   st, bc, nlog;
  logic [7:0] sh;
  logic [2:0] ptr;
  logic [7:0] rxlog [4];

  always @(posedge clk) begin
    ps <= scl_line;
    pd <= sda_line;
    if (rst) begin
      st <= 0; bc <= 0; nlog <= 0; slv_low <= 1'b0; ptr <= '0; addr_ph <= 1'b0;
      go_tx <= 1'b0; acked <= 1'b0; sh <= '0;
    end else if (ps && scl_line && pd && !sda_line) begin
      st <= 1; bc <= 0; addr_ph <= 1'b1; slv_low <= 1'b0;
    end else if (ps && scl_line && !pd && sda_line) begin
      st <= 0; slv_low <= 1'b0;
    end else if (!ps && scl_line) begin
      if (st == 1 && bc < 8) sh <= {sh[6:0], sda_line};
      if (st == 2 && bc == 8) acked <= !sda_line;
      bc <= bc + 1;
    end else if (ps && !scl_line) begin
      if (st == 1 && bc == 8) begin
        if (nlog < 4) rxlog[nlog] <= sh;
        nlog <= nlog + 1;
        if (addr_ph) begin
          if (present && sh[7:1] == 7'h50) begin
            slv_low <= 1'b1; go_tx <= sh[0]; addr_ph <= 1'b0;
          end else begin
            st <= 0; slv_low <= 1'b0;
          end
        end else begin
          ptr <= sh[2:0]; slv_low <= 1'b1; go_tx <= 1'b0;
        end
      end else if (st == 1 && bc == 9) begin
        bc <= 0;
        if (go_tx) begin
          st <= 2; sh <= mem[ptr]; slv_low <= !mem[ptr][7];
        end else slv_low <= 1'b0;
      end else if (st == 2 && bc < 8) begin
        slv_low <= !sh[7 - bc];
      end else if (st == 2 && bc == 8) begin
        slv_low <= 1'b0;
      end else if (st == 2 && bc == 9) begin
        if (acked) begin
          ptr <= ptr + 3'd1; sh <= mem[ptr + 3'd1];
          slv_low <= !mem[ptr + 3'd1][7]; bc <= 0;
        end else begin
          st <= 0;
        end
      end
    end
  end

  typedef struct {
    logic [15:0] vid, pid;
    logic [7:0]  attr, maxpwr;
    logic        rwake, bus, pol, rom, expect_bus;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic case_done = 1'b0, finished = 1'b0;
  int bus_cycles = 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input logic sigok);
    exp_t e;
    logic usebus = sda_pull & scl_pull;
    e.pol = lowpwr;
    e.expect_bus = usebus;
    if (usebus && present && sigok) begin
      e.vid = {mem[1], mem[0]}; e.pid = {mem[3], mem[2]};
      e.attr = mem[4]; e.maxpwr = mem[5];
      e.rwake = mem[4][5]; e.bus = !mem[4][6]; e.rom = 1'b1;
    end else begin
      e.vid = 16'h04E2; e.pid = 16'h1410; e.maxpwr = 8'h32;
      e.rwake = !sda_pull; e.bus = !scl_pull;
      e.attr = 8'h80 | (e.bus ? 8'h00 : 8'h40) | (e.rwake ? 8'h20 : 8'h00);
      e.rom = 1'b0;
    end
    return e;
  endfunction

  task automatic run_case(input logic pres, input logic sp, input logic cp, input logic lp,
                          input logic [7:0] b [8]);
    for (int i = 0; i < 8; i++) mem[i] = b[i];
    present = pres; sda_pull = sp; scl_pull = cp; lowpwr = lp;
    q.push_back(model(b[7] == 8'h58));
    case_done = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(!done && vid == 0 && pid == 0 && attr == 0 && maxpwr == 0 && !rwake && !buspwr
        && !romu && !spol && !scl_oe && !sda_oe, "R1 reset state",
        {vid, pid, attr, maxpwr, 8'(done)}, 64'h0);
    bus_cycles = 0;
    rst = 1'b0;
    @(negedge clk);
    chk(!done && vid == 0, "R1 first cycle after reset", {48'h0, vid}, 64'h0);
    wait (case_done);
    if (present && sp && cp) begin
      // R2
      chk(nlog == 3 && rxlog[0] == 8'hA0 && rxlog[1] == 8'h00 && rxlog[2] == 8'hA1,
          "R2 bus sequence", {rxlog[0], rxlog[1], rxlog[2], 8'(nlog)}, 64'hA000A103);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (scl_oe || sda_oe)) bus_cycles++;
      if (!rst && done) begin
        exp_t e;
        logic [63:0] snap;
        e = q.pop_front();
        chk(vid == e.vid, e.rom ? "R3 vid" : "R5 vid", 64'(vid), 64'(e.vid));
        chk(pid == e.pid, e.rom ? "R3 pid" : "R5 pid", 64'(pid), 64'(e.pid));
        chk(maxpwr == e.maxpwr, e.rom ? "R3 maxpwr" : "R5 maxpwr", 64'(maxpwr), 64'(e.maxpwr));
        chk(attr == e.attr, e.rom ? "R3 attr" : "R7 attr", 64'(attr), 64'(e.attr));
        chk(rwake == e.rwake && buspwr == e.bus, e.rom ? "R4 wake/bus" : "R7 wake/bus",
            {62'h0, rwake, buspwr}, {62'h0, e.rwake, e.bus});
        chk(romu == e.rom, "R6 rom_used", 64'(romu), 64'(e.rom));
        chk(spol == e.pol, "R9 suspend polarity", 64'(spol), 64'(e.pol));
        if (!e.expect_bus)
          chk(bus_cycles == 0, "R8 no bus access", 64'(bus_cycles), 64'h0);
        else
          chk(bus_cycles > 0, "R2 bus used", 64'(bus_cycles), 64'h1);
        snap = {vid, pid, attr, maxpwr, rwake, buspwr, spol, romu, 4'h0};
        @(negedge clk);
        chk(!done, "R10 done one cycle", 64'(done), 64'h0);
        repeat (40) @(negedge clk);
        chk(snap == {vid, pid, attr, maxpwr, rwake, buspwr, spol, romu, 4'h0} && !done,
            "R10 outputs hold", {vid, pid, attr, maxpwr, rwake, buspwr, spol, romu, 4'h0}, snap);
        chk(bus_cycles < 100000 && !scl_oe && !sda_oe, "R2 lines released after STOP",
            {62'h0, scl_oe, sda_oe}, 64'h0);
        case_done = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] good1 [8] = '{8'hEF, 8'hBE, 8'h34, 8'h12, 8'hA0, 8'h64, 8'h00, 8'h58};
    logic [7:0] good2 [8] = '{8'h01, 8'h80, 8'hFE, 8'h7F, 8'hC0, 8'hFA, 8'h55, 8'h58};
    logic [7:0] badsg [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hE0, 8'h10, 8'h00, 8'h59};
    // R3 R4: valid record, bus-powered with wake-up
    run_case(1'b1, 1'b1, 1'b1, 1'b1, good1);
    // R3 R4: valid record, self-powered without wake-up
    run_case(1'b1, 1'b1, 1'b1, 1'b0, good2);
    // R5: signature mismatch
    run_case(1'b1, 1'b1, 1'b1, 1'b1, badsg);
    // R6: no device acknowledges
    run_case(1'b0, 1'b1, 1'b1, 1'b0, good1);
    // R7 R8: straps 10, 01, 00
    run_case(1'b0, 1'b1, 1'b0, 1'b1, good1);
    run_case(1'b0, 1'b0, 1'b1, 1'b0, good1);
    run_case(1'b0, 1'b0, 1'b0, 1'b1, good1);
    // R8: valid memory present but data strap low
    run_case(1'b1, 1'b0, 1'b1, 1'b0, good1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule